// File: doc/BRIEF.md
# AHB Burst to Fixed-Length Command Adapter

This block is the front end of a static-memory controller. It takes AHB 2.0 transfers from one slave port and reissues them on a simple internal channel. That channel carries a command (address, length, wrap flag, direction), a write-beat handshake, a read-beat handshake and a write-response pulse. Every internal command has a length that is known when it is issued. AHB bursts with a fixed beat count map one-to-one. A burst of undefined length is cut into four-beat incrementing groups, so the memory side never sees a stream of single transfers.

Write data is stored in a register before it goes to the internal write path. Writes marked bufferable are acknowledged on AHB as soon as the data is handed over. A write marked non-bufferable waits on two points. First, its command waits until every earlier write has reported back. Second, its final beat waits until its own response has also returned. A static tie-off selects 32-bit big-endian byte-lane mapping for both write and read data.

Top module: `ahb_fixlen_adapter`

## Requirements
- R1: HBURST codes map to `cmd_len` as beats minus one. SINGLE(0) gives 0, WRAP4(2) and INCR4(3) give 3, WRAP8(4) and INCR8(5) give 7, WRAP16(6) and INCR16(7) give 15. `cmd_wrap` is 1 only for the WRAP codes.
- R2: An undefined-length INCR(1) burst is issued as commands with `cmd_len`=3 and `cmd_wrap`=0. A new command starts every fourth beat, and its `cmd_addr` is the AHB address of the first beat of its group.
- R3: When the master ends a group early (IDLE, deselect or NONSEQ), the adapter completes the group's remaining beats itself. Write beats are sent with `wr_strb`=0 and read beats are taken and dropped. `wr_last` is 1 on the final beat of every command.
- R4: HWDATA is captured into a register in the first data-phase cycle. `wr_data`/`wr_strb` are driven from that register and held stable while `wr_valid` is high and `wr_ready` is low.
- R5: A bufferable write (HPROT[2]=1) completes on AHB once its beat is accepted on the write channel, without waiting for `bresp_valid`.
- R6: A non-bufferable write command (HPROT[2]=0) is not presented on `cmd_valid` while any earlier write command still lacks its `bresp_valid` pulse.
- R7: The beat that completes a non-bufferable write command is not acknowledged on AHB until its own `bresp_valid` has returned.
- R8: With `big_endian`=1, bytes are reversed within each 32-bit lane (byte 0 swaps with byte 3, byte 1 with byte 2) on both write and read data. With 0, data passes unchanged.
- R9: IDLE(0) and BUSY(1) HTRANS cycles produce no command. HRESP is always OKAY (0).
- R10: While reset is held, `hreadyout`=1 and `cmd_valid`, `wr_valid` and `rd_ready` are 0.
- R11: Once `cmd_valid` is raised it stays high, with `cmd_addr` and `cmd_len` unchanged, until `cmd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| big_endian | input | 1 | Static tie-off selecting byte-reversed 32-bit lanes |
| hsel | input | 1 | AHB slave select |
| hready_in | input | 1 | AHB bus ready |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write flag |
| hsize | input | 3 | AHB transfer size |
| hburst | input | 3 | AHB burst type |
| hprot | input | 4 | AHB protection; bit 2 marks bufferable |
| hwdata | input | DATA_W | AHB write data |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | Slave response, always OKAY |
| hrdata | output | DATA_W | AHB read data |
| cmd_valid | output | 1 | Internal command valid |
| cmd_ready | input | 1 | Internal command accepted |
| cmd_addr | output | 32 | Command start address |
| cmd_write | output | 1 | Command direction |
| cmd_len | output | 4 | Beats minus one |
| cmd_wrap | output | 1 | Wrapping burst |
| cmd_size | output | 3 | Beat size, copied from HSIZE |
| cmd_bufable | output | 1 | Command is bufferable |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_data | output | DATA_W | Write beat data |
| wr_strb | output | DATA_W/8 | Byte strobes, zero on filler beats |
| wr_last | output | 1 | Final beat of command |
| rd_valid | input | 1 | Read beat valid |
| rd_ready | output | 1 | Read beat taken |
| rd_data | input | DATA_W | Read beat data |
| bresp_valid | input | 1 | One write command finished |

## Verification
The checks assume that the memory side sends exactly one `bresp_valid` pulse per accepted write command and never sends one before that command. They also assume the AHB side has this adapter as its only slave, so `hready_in` follows `hreadyout`, and that the master holds HWDATA for the whole data phase. The bench's memory model returns each response a fixed three cycles after a command's last write beat, or on demand in the ordering tests. Its master task keeps address and data steady while the adapter stalls, and inserts BUSY and IDLE only between groups.

// File: rtl/ahbfl_pkg.sv
package ahbfl_pkg;
    localparam int unsigned ADDR_W = 32;

    typedef enum logic [1:0] {TR_IDLE = 2'd0, TR_BUSY = 2'd1, TR_NSEQ = 2'd2, TR_SEQ = 2'd3} trans_e;

    localparam logic [2:0] BU_SINGLE = 3'd0;
    localparam logic [2:0] BU_INCR   = 3'd1;
    localparam logic [2:0] BU_WRAP4  = 3'd2;
    localparam logic [2:0] BU_INCR4  = 3'd3;
    localparam logic [2:0] BU_WRAP8  = 3'd4;
    localparam logic [2:0] BU_INCR8  = 3'd5;
    localparam logic [2:0] BU_WRAP16 = 3'd6;
    localparam logic [2:0] BU_INCR16 = 3'd7;

    typedef enum logic [2:0] {
        S_OPEN, S_CMD, S_WCAP, S_WPUSH, S_WAITB, S_RD, S_PAD
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [2:0]        size;
        logic              bufable;
        logic [2:0]        burst;
    } xfer_t;
endpackage

// File: rtl/ahbfl_burst_map.sv
module ahbfl_burst_map
    import ahbfl_pkg::*;
(
    input  logic [2:0] burst,
    output logic [3:0] len_m1,
    output logic       wrap
);
    always_comb begin
        wrap = 1'b0;
        unique case (burst)
            BU_SINGLE:           len_m1 = 4'd0;
            BU_INCR:             len_m1 = 4'd3;
            BU_WRAP4, BU_INCR4:  len_m1 = 4'd3;
            BU_WRAP8, BU_INCR8:  len_m1 = 4'd7;
            default:             len_m1 = 4'd15;
        endcase
        if (burst == BU_WRAP4 || burst == BU_WRAP8 || burst == BU_WRAP16)
            wrap = 1'b1;
    end
endmodule

// File: rtl/ahbfl_lane_swap.sv
module ahbfl_lane_swap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned WORDS = DATA_W / 32;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            assign dout[w*32 + b*8 +: 8] = en ? din[w*32 + (3-b)*8 +: 8]
                                              : din[w*32 + b*8 +: 8];
        end
    end
endmodule

// File: rtl/ahbfl_wr_tracker.sv
module ahbfl_wr_tracker #(
    parameter int unsigned OUT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic none_out
);
    logic [OUT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign none_out = (cnt_q == '0);
endmodule

// File: rtl/ahb_fixlen_adapter.sv
module ahb_fixlen_adapter
    import ahbfl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OUT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 big_endian,
    input  logic                 hsel,
    input  logic                 hready_in,
    input  logic [ADDR_W-1:0]    haddr,
    input  logic [1:0]           htrans,
    input  logic                 hwrite,
    input  logic [2:0]           hsize,
    input  logic [2:0]           hburst,
    input  logic [3:0]           hprot,
    input  logic [DATA_W-1:0]    hwdata,
    output logic                 hreadyout,
    output logic                 hresp,
    output logic [DATA_W-1:0]    hrdata,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic                 cmd_write,
    output logic [3:0]           cmd_len,
    output logic                 cmd_wrap,
    output logic [2:0]           cmd_size,
    output logic                 cmd_bufable,
    output logic                 wr_valid,
    input  logic                 wr_ready,
    output logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W/8-1:0]  wr_strb,
    output logic                 wr_last,
    input  logic                 rd_valid,
    output logic                 rd_ready,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic                 bresp_valid
);
    localparam int unsigned STRB_W = DATA_W / 8;
    localparam int unsigned BEAT_W = 5;

    state_e              state_q;
    xfer_t               lat_q;
    logic [BEAT_W-1:0]   beats_q;
    logic                pend_q;
    logic                act_write_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;

    logic [3:0]          map_len;
    logic                map_wrap;
    logic [DATA_W-1:0]   wsw, rsw;
    logic                none_out;
    logic                nb_block, cmd_hs, pad_hs, xfer_ok, stop_req, beat_one;

    ahbfl_burst_map u_map (.burst(lat_q.burst), .len_m1(map_len), .wrap(map_wrap));

    ahbfl_lane_swap #(.DATA_W(DATA_W)) u_wsw (.en(big_endian), .din(hwdata),  .dout(wsw));
    ahbfl_lane_swap #(.DATA_W(DATA_W)) u_rsw (.en(big_endian), .din(rd_data), .dout(rsw));

    ahbfl_wr_tracker #(.OUT_W(OUT_W)) u_trk (
        .clk(clk), .rst(rst),
        .inc(cmd_hs && lat_q.write), .dec(bresp_valid),
        .none_out(none_out)
    );

    always_comb begin
        xfer_ok   = hsel && hready_in && htrans[1];
        stop_req  = hready_in && !(hsel && htrans == TR_BUSY);
        beat_one  = (beats_q == BEAT_W'(1));
        nb_block  = lat_q.write && !lat_q.bufable && !none_out;
        hreadyout = (state_q == S_OPEN);
        hresp     = 1'b0;
        hrdata    = rdata_q;
        cmd_valid = (state_q == S_CMD) && !nb_block;
        cmd_hs    = cmd_valid && cmd_ready;
        cmd_addr  = lat_q.addr;
        cmd_write = lat_q.write;
        cmd_len   = map_len;
        cmd_wrap  = map_wrap;
        cmd_size  = lat_q.size;
        cmd_bufable = lat_q.bufable;
        wr_valid  = (state_q == S_WPUSH) || (state_q == S_PAD && act_write_q);
        wr_data   = wdata_q;
        wr_strb   = (state_q == S_PAD) ? '0 : {STRB_W{1'b1}};
        wr_last   = beat_one;
        rd_ready  = (state_q == S_RD) || (state_q == S_PAD && !act_write_q);
        pad_hs    = act_write_q ? wr_ready : rd_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_OPEN;
            lat_q       <= '0;
            beats_q     <= '0;
            pend_q      <= 1'b0;
            act_write_q <= 1'b0;
            wdata_q     <= '0;
            rdata_q     <= '0;
        end else begin
            unique case (state_q)
                S_OPEN: begin
                    if (xfer_ok) begin
                        lat_q <= '{addr: haddr, write: hwrite, size: hsize,
                                   bufable: hprot[2], burst: hburst};
                        if (htrans == TR_NSEQ || beats_q == '0) begin
                            pend_q  <= 1'b1;
                            state_q <= (beats_q != '0) ? S_PAD : S_CMD;
                        end else begin
                            state_q <= hwrite ? S_WCAP : S_RD;
                        end
                    end else if (stop_req && beats_q != '0) begin
                        pend_q  <= 1'b0;
                        state_q <= S_PAD;
                    end
                end
                S_CMD: begin
                    if (cmd_hs) begin
                        beats_q     <= BEAT_W'(map_len) + 1'b1;
                        act_write_q <= lat_q.write;
                        state_q     <= lat_q.write ? S_WCAP : S_RD;
                    end
                end
                S_WCAP: begin
                    wdata_q <= wsw;
                    state_q <= S_WPUSH;
                end
                S_WPUSH: begin
                    if (wr_ready) begin
                        beats_q <= beats_q - 1'b1;
                        state_q <= (!lat_q.bufable && beat_one) ? S_WAITB : S_OPEN;
                    end
                end
                S_WAITB: begin
                    if (none_out) state_q <= S_OPEN;
                end
                S_RD: begin
                    if (rd_valid) begin
                        rdata_q <= rsw;
                        beats_q <= beats_q - 1'b1;
                        state_q <= S_OPEN;
                    end
                end
                S_PAD: begin
                    if (pad_hs) begin
                        beats_q <= beats_q - 1'b1;
                        if (beat_one) state_q <= pend_q ? S_CMD : S_OPEN;
                    end
                end
                default: state_q <= S_OPEN;
            endcase
        end
    end
endmodule

// File: rtl/ahbfl_chk.sv
module ahbfl_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [31:0]       cmd_addr,
    input logic [3:0]        cmd_len,
    input logic              cmd_write,
    input logic              cmd_bufable,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W/8-1:0] wr_strb,
    input logic              bresp_valid,
    input logic              hreadyout,
    input logic              rd_ready
);
    logic [7:0] open_wr;

    always_ff @(posedge clk) begin
        if (rst) open_wr <= '0;
        else if (cmd_valid && cmd_ready && cmd_write && !bresp_valid) open_wr <= open_wr + 1'b1;
        else if (bresp_valid && !(cmd_valid && cmd_ready && cmd_write)) open_wr <= open_wr - 1'b1;
    end

    // R1
    len_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len == 4'd0 || cmd_len == 4'd3 || cmd_len == 4'd7 || cmd_len == 4'd15));

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_strb));

    // R6
    nb_order_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_write && !cmd_bufable |-> open_wr == 8'd0);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> hreadyout && !cmd_valid && !wr_valid && !rd_ready);
endmodule

bind ahb_fixlen_adapter ahbfl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write),
    .cmd_bufable(cmd_bufable), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_strb(wr_strb), .bresp_valid(bresp_valid),
    .hreadyout(hreadyout), .rd_ready(rd_ready)
);

// File: tb/ahb_fixlen_adapter_tb.sv
`timescale 1ns/1ps
module ahb_fixlen_adapter_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        big_endian = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [2:0]  hburst = 3'd0;
    logic [3:0]  hprot = 4'b0111;
    logic [31:0] hwdata = '0;
    logic        hreadyout, hresp;
    logic [31:0] hrdata;
    logic        cmd_valid, cmd_write, cmd_wrap, cmd_bufable;
    logic [31:0] cmd_addr;
    logic [3:0]  cmd_len;
    logic [2:0]  cmd_size;
    logic        wr_valid, wr_last, rd_ready;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;
    logic        cmd_rdy_en = 1'b1, wr_rdy_en = 1'b1, auto_b = 1'b1, man_b = 1'b0;
    logic [2:0]  bq;
    int          cmd_n = 0, wr_n = 0, rd_n = 0;
    logic [31:0] rd_data;
    logic        bresp_valid;

    assign rd_data     = 32'hC0DE_0000 + rd_n;
    assign bresp_valid = bq[2] | man_b;

    ahb_fixlen_adapter u_dut (
        .clk(clk), .rst(rst), .big_endian(big_endian), .hsel(hsel), .hready_in(hreadyout),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
        .hprot(hprot), .hwdata(hwdata), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_rdy_en), .cmd_addr(cmd_addr), .cmd_write(cmd_write),
        .cmd_len(cmd_len), .cmd_wrap(cmd_wrap), .cmd_size(cmd_size), .cmd_bufable(cmd_bufable),
        .wr_valid(wr_valid), .wr_ready(wr_rdy_en), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_last(wr_last), .rd_valid(1'b1), .rd_ready(rd_ready), .rd_data(rd_data),
        .bresp_valid(bresp_valid)
    );

    // logs of the internal channel
    logic [31:0] c_addr [0:63];
    logic [3:0]  c_len  [0:63];
    logic        c_wrap [0:63];
    logic        c_wr   [0:63];
    logic [31:0] w_data [0:63];
    logic [3:0]  w_strb [0:63];
    logic        w_last [0:63];
    logic [31:0] rdc    [0:15];

    always @(posedge clk) begin
        if (rst) bq <= '0;
        else     bq <= {bq[1:0], wr_valid && wr_rdy_en && wr_last && auto_b};
        if (!rst && cmd_valid && cmd_rdy_en) begin
            c_addr[cmd_n % 64] <= cmd_addr; c_len[cmd_n % 64] <= cmd_len;
            c_wrap[cmd_n % 64] <= cmd_wrap; c_wr[cmd_n % 64]  <= cmd_write;
            cmd_n <= cmd_n + 1;
        end
        if (!rst && wr_valid && wr_rdy_en) begin
            w_data[wr_n % 64] <= wr_data; w_strb[wr_n % 64] <= wr_strb;
            w_last[wr_n % 64] <= wr_last; wr_n <= wr_n + 1;
        end
        if (!rst && rd_ready) rd_n <= rd_n + 1;
    end

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wpat(input logic [31:0] a, input int i);
        return {16'h5A5A, a[15:0]} + 32'(i);
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic ahb_run(input logic [2:0] b, input bit w, input bit bf,
                           input logic [31:0] a, input int n);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i < n) begin
                hsel = 1'b1; htrans = (i == 0) ? 2'b10 : 2'b11; haddr = a + 32'(4 * i);
                hwrite = w; hburst = b; hprot = {1'b0, bf, 2'b11}; hsize = 3'd2;
            end else begin
                hsel = 1'b0; htrans = 2'b00;
            end
            if (i > 0) hwdata = wpat(a, i - 1);
            while (!hreadyout) @(negedge clk);
            if (i > 0 && !w) rdc[i-1] = hrdata;
        end
    endtask

    typedef struct packed {
        logic [2:0]  bu;
        logic        wr;
        logic [15:0] addr;
        logic [4:0]  n;
        logic [1:0]  ncmd;
        logic [3:0]  len;
        logic        wrap;
        logic [4:0]  nb;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 1'b1, 16'h0100, 5'd1,  2'd1, 4'd0,  1'b0, 5'd1},
        '{3'd3, 1'b1, 16'h0200, 5'd4,  2'd1, 4'd3,  1'b0, 5'd4},
        '{3'd4, 1'b0, 16'h0300, 5'd8,  2'd1, 4'd7,  1'b1, 5'd8},
        '{3'd7, 1'b1, 16'h0400, 5'd16, 2'd1, 4'd15, 1'b0, 5'd16},
        '{3'd1, 1'b1, 16'h0500, 5'd6,  2'd2, 4'd3,  1'b0, 5'd8},
        '{3'd1, 1'b0, 16'h0600, 5'd3,  2'd1, 4'd3,  1'b0, 5'd4},
        '{3'd2, 1'b1, 16'h0700, 5'd4,  2'd1, 4'd3,  1'b1, 5'd4},
        '{3'd1, 1'b1, 16'h0800, 5'd8,  2'd2, 4'd3,  1'b0, 5'd8},
        '{3'd5, 1'b0, 16'h0900, 5'd8,  2'd1, 4'd7,  1'b0, 5'd8}
    };

    bit nb_done = 1'b0, rd_done = 1'b0, wr_done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(hreadyout && !cmd_valid && !wr_valid && !rd_ready, "R10", {28'd0, hreadyout, cmd_valid, wr_valid, rd_ready}, 32'h8);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            vec_t t;
            int cb, wb, rb;
            string rq;
            bit ok;
            t = VECS[v];
            rq = (t.bu == 3'd1) ? "R2" : "R1";
            cb = cmd_n; wb = wr_n; rb = rd_n;
            ahb_run(t.bu, t.wr, 1'b1, {16'h0, t.addr}, int'(t.n));
            repeat (8) @(negedge clk);
            chk(cmd_n - cb == int'(t.ncmd), rq, 32'(cmd_n - cb), 32'(t.ncmd));
            chk(c_len[cb % 64] == t.len && c_wrap[cb % 64] == t.wrap, rq,
                {27'd0, c_wrap[cb % 64], c_len[cb % 64]}, {27'd0, t.wrap, t.len});
            chk(c_addr[cb % 64] == {16'h0, t.addr} && c_wr[cb % 64] == t.wr, rq,
                c_addr[cb % 64], {16'h0, t.addr});
            if (t.ncmd == 2'd2)
                chk(c_addr[(cb + 1) % 64] == {16'h0, t.addr} + 32'd16, "R2",
                    c_addr[(cb + 1) % 64], {16'h0, t.addr} + 32'd16);
            if (t.wr) begin
                // R3 beat count includes filler beats
                chk(wr_n - wb == int'(t.nb), "R3", 32'(wr_n - wb), 32'(t.nb));
                ok = 1'b1;
                for (int i = 0; i < int'(t.nb); i++) begin
                    if (i < int'(t.n)) ok &= (w_data[(wb + i) % 64] == wpat({16'h0, t.addr}, i)) && (w_strb[(wb + i) % 64] == 4'hF);
                    else               ok &= (w_strb[(wb + i) % 64] == 4'h0);
                    ok &= (w_last[(wb + i) % 64] == (((i + 1) % (int'(t.len) + 1)) == 0));
                end
                chk(ok, "R4", w_data[wb % 64], wpat({16'h0, t.addr}, 0));
            end else begin
                chk(rd_n - rb == int'(t.nb), "R3", 32'(rd_n - rb), 32'(t.nb));
                ok = 1'b1;
                for (int i = 0; i < int'(t.n); i++) ok &= (rdc[i] == 32'hC0DE_0000 + 32'(rb + i));
                chk(ok, rq, rdc[0], 32'hC0DE_0000 + 32'(rb));
            end
        end

        // R9 BUSY and IDLE create nothing
        begin
            int cb;
            cb = cmd_n;
            @(negedge clk); hsel = 1'b1; htrans = 2'b01;
            repeat (3) @(negedge clk);
            htrans = 2'b00;
            repeat (3) @(negedge clk);
            hsel = 1'b0;
            chk(cmd_n == cb && hresp == 1'b0 && hreadyout, "R9", 32'(cmd_n - cb), 32'd0);
        end

        // R8 big-endian mapping
        big_endian = 1'b1;
        begin
            int wb, rb;
            wb = wr_n; rb = rd_n;
            ahb_run(3'd0, 1'b1, 1'b1, 32'h40, 1);
            repeat (4) @(negedge clk);
            chk(w_data[wb % 64] == bswap(wpat(32'h40, 0)), "R8", w_data[wb % 64], bswap(wpat(32'h40, 0)));
            ahb_run(3'd0, 1'b0, 1'b1, 32'h44, 1);
            chk(rdc[0] == bswap(32'hC0DE_0000 + 32'(rb)), "R8", rdc[0], bswap(32'hC0DE_0000 + 32'(rb)));
        end
        big_endian = 1'b0;
        repeat (6) @(negedge clk);

        // R11 command held under back-pressure
        cmd_rdy_en = 1'b0;
        fork
            begin ahb_run(3'd0, 1'b0, 1'b1, 32'hA00, 1); rd_done = 1'b1; end
        join_none
        repeat (4) @(negedge clk);
        chk(cmd_valid && cmd_addr == 32'hA00, "R11", cmd_addr, 32'hA00);
        repeat (3) @(negedge clk);
        chk(cmd_valid && cmd_addr == 32'hA00 && cmd_len == 4'd0, "R11", cmd_addr, 32'hA00);
        cmd_rdy_en = 1'b1;
        wait (rd_done);
        repeat (4) @(negedge clk);

        // R4 registered write data held under back-pressure
        wr_rdy_en = 1'b0;
        fork
            begin ahb_run(3'd0, 1'b1, 1'b1, 32'hB00, 1); wr_done = 1'b1; end
        join_none
        repeat (6) @(negedge clk);
        chk(wr_valid && wr_data == wpat(32'hB00, 0), "R4", wr_data, wpat(32'hB00, 0));
        repeat (3) @(negedge clk);
        chk(wr_valid && wr_data == wpat(32'hB00, 0), "R4", wr_data, wpat(32'hB00, 0));
        wr_rdy_en = 1'b1;
        wait (wr_done);
        repeat (8) @(negedge clk);

        // R5, R6, R7 ordering with responses under bench control
        auto_b = 1'b0;
        begin
            int cb, t0;
            cb = cmd_n; t0 = 0;
            fork
                ahb_run(3'd0, 1'b1, 1'b1, 32'hC00, 1);
                begin while (1) begin @(negedge clk); t0++; end end
            join_any
            disable fork;
            // R5 bufferable write finished with no response returned
            chk(t0 < 12, "R5", 32'(t0), 32'd12);
            fork
                begin ahb_run(3'd0, 1'b1, 1'b0, 32'hC04, 1); nb_done = 1'b1; end
            join_none
            repeat (8) @(negedge clk);
            chk(cmd_n - cb == 1, "R6", 32'(cmd_n - cb), 32'd1);
            man_b = 1'b1; @(negedge clk); man_b = 1'b0;
            repeat (6) @(negedge clk);
            chk(cmd_n - cb == 2, "R6", 32'(cmd_n - cb), 32'd2);
            chk(!nb_done && !hreadyout, "R7", {31'd0, nb_done}, 32'd0);
            man_b = 1'b1; @(negedge clk); man_b = 1'b0;
            repeat (6) @(negedge clk);
            chk(nb_done, "R7", {31'd0, nb_done}, 32'd1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule